// File: doc/BRIEF.md
# Dual-Ratio Clock Coincidence Sync Generator

This block derives two output clocks, A and C, from a single fast clock. Each output comes from an integer divider. A ratio select input sets the frequency relation between A and C. The supported relations include non-binary ones such as 3:2, 5:3 and 6:5.

The block also drives an active-low sync pulse. The pulse goes low one half-period of the faster output ahead of every rising edge that A and C share, so downstream logic can prepare for the aligned edge. Both output clocks and the sync pulse are registered levels on the fast clock.

For a ratio A:C = p:q (in lowest terms), the fast clock is taken to run at 2·p·q times the common base rate. A therefore toggles every q fast cycles, C toggles every p fast cycles, and their rising edges coincide every 2·p·q fast cycles. The ratio is sampled only while reset is held. A synchronous reset aligns all the dividers to a common phase.

Top module: `clksync_gen`

## Requirements
- R1: `ratio_sel` selects A:C as follows: 0→1:1, 1→2:1, 2→3:1, 3→3:2, 4→4:1, 5→4:3, 6→5:1, 7→5:2, 8→5:3, 9→6:1, 10→6:5. Codes 11 to 15 behave as 1:1.
- R2: On any fast-clock edge with `rst_n` low, `clk_a`, `clk_c` and `sync_n` become 1 and all internal counters clear.
- R3: Let n be the number of fast edges since reset was released. After edge n, `clk_a` equals 1 exactly when floor(n/q) is even. This gives a period of 2q fast cycles with a 50% duty cycle.
- R4: After edge n, `clk_c` equals 1 exactly when floor(n/p) is even. This gives a period of 2p fast cycles.
- R5: The rising edges of A and C coincide at every edge n that is a nonzero multiple of T = 2·p·q, and at no other edge.
- R6: After edge n, `sync_n` is 0 exactly when (n mod T) ≥ T−q. It therefore falls one A half-period before each coincident rising edge and rises at that edge. It falls once per coincidence period.
- R7: For the 1:1 ratio, `sync_n` is low for one fast cycle in every output period.
- R8: Changes of `ratio_sel` while `rst_n` is high have no effect. The ratio captured on the last reset edge stays in force until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset; also captures the ratio |
| ratio_sel | input | 4 | Ratio code, see R1 |
| clk_a | output | 1 | Divided clock A (the faster or equal output) |
| clk_c | output | 1 | Divided clock C |
| sync_n | output | 1 | Active-low warning of the next shared rising edge |

## Verification
The embedded assertions check the following on every cycle:
- each divider output holds still while its half-period counter is mid-count;
- the shared phase stays below the coincidence period;
- every joint rise of A and C is preceded by a low sync;
- sync releases only on such a joint rise;
- the captured ratio stays frozen outside reset.

Only the bench scenarios can show that each select code yields the right pair of periods and that coincidences arrive at the exact predicted count per period. The same holds for the 1:1 sync cadence and for a mid-run select change leaving the waveform untouched.

// File: rtl/clksync_pkg.sv
// Package: shared widths, ratio type and select-code decoding for the
// coincidence sync generator. Assumes output multipliers never exceed MULT_MAX.
package clksync_pkg;
    localparam int MULT_MAX = 6;
    localparam int MULT_W   = $clog2(MULT_MAX + 1);
    localparam int SEL_W    = 4;
    localparam int PER_MAX  = 2 * MULT_MAX * MULT_MAX;
    localparam int PER_W    = $clog2(PER_MAX + 1);

    // Frequency multipliers of A and C relative to the common base rate
    typedef struct packed {
        logic [MULT_W-1:0] mul_a;
        logic [MULT_W-1:0] mul_c;
    } ratio_t;

    // Map a select code to its multiplier pair; unknown codes give 1:1
    function automatic ratio_t decode_ratio(input logic [SEL_W-1:0] code);
        ratio_t r;
        case (code)
            4'd1:    begin r.mul_a = MULT_W'(2); r.mul_c = MULT_W'(1); end
            4'd2:    begin r.mul_a = MULT_W'(3); r.mul_c = MULT_W'(1); end
            4'd3:    begin r.mul_a = MULT_W'(3); r.mul_c = MULT_W'(2); end
            4'd4:    begin r.mul_a = MULT_W'(4); r.mul_c = MULT_W'(1); end
            4'd5:    begin r.mul_a = MULT_W'(4); r.mul_c = MULT_W'(3); end
            4'd6:    begin r.mul_a = MULT_W'(5); r.mul_c = MULT_W'(1); end
            4'd7:    begin r.mul_a = MULT_W'(5); r.mul_c = MULT_W'(2); end
            4'd8:    begin r.mul_a = MULT_W'(5); r.mul_c = MULT_W'(3); end
            4'd9:    begin r.mul_a = MULT_W'(6); r.mul_c = MULT_W'(1); end
            4'd10:   begin r.mul_a = MULT_W'(6); r.mul_c = MULT_W'(5); end
            default: begin r.mul_a = MULT_W'(1); r.mul_c = MULT_W'(1); end
        endcase
        return r;
    endfunction
endpackage

// File: rtl/clksync_ratio_latch.sv
// Ratio latch: captures the decoded ratio while reset is held and derives the
// half-period of each output and the coincidence period. Assumes the select
// input is stable around the final reset edge.
module clksync_ratio_latch
    import clksync_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic [MULT_W-1:0] half_a,
    output logic [MULT_W-1:0] half_c,
    output logic [PER_W-1:0]  period
);
    ratio_t             dec;
    logic [PER_W-1:0]   per_next;

    // Decode the select code and compute 2*p*q
    always_comb begin
        dec      = decode_ratio(sel);
        per_next = PER_W'(2 * int'(dec.mul_a) * int'(dec.mul_c));
    end

    // Capture on reset edges only; A half-period is q, C half-period is p
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_a <= dec.mul_c;
            half_c <= dec.mul_a;
            period <= per_next;
        end
    end

    // R8
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ($stable(period) && $stable(half_a) && $stable(half_c)));
endmodule

// File: rtl/clksync_half_div.sv
// Half-period divider: toggles its output every 'half' fast cycles and starts
// high after reset. Assumes 'half' is nonzero and constant outside reset.
module clksync_half_div #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] half,
    output logic         clk_o
);
    logic [W-1:0] cnt;

    // Count fast cycles and flip the output at the end of each half-period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            clk_o <= 1'b1;
        end else if (cnt == half - W'(1)) begin
            cnt   <= '0;
            clk_o <= ~clk_o;
        end else begin
            cnt   <= cnt + W'(1);
        end
    end

    // R3 R4
    mid_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> $stable(clk_o));
endmodule

// File: rtl/clksync_phase_ctr.sv
// Phase counter: runs modulo the coincidence period and drives the active-low
// sync low for the final 'lead' fast cycles before each wrap. Assumes
// lead < period.
module clksync_phase_ctr
    import clksync_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PER_W-1:0]  period,
    input  logic [MULT_W-1:0] lead,
    output logic              sync_n
);
    logic [PER_W-1:0] phase;
    logic [PER_W-1:0] phase_nxt;
    logic [PER_W-1:0] warn_from;

    // Next phase and the first phase of the warning window
    always_comb begin
        phase_nxt = (phase == period - PER_W'(1)) ? '0 : phase + PER_W'(1);
        warn_from = period - PER_W'(lead);
    end

    // Advance the phase and register sync from the upcoming phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= '0;
            sync_n <= 1'b1;
        end else begin
            phase  <= phase_nxt;
            sync_n <= !(phase_nxt >= warn_from);
        end
    end

    // R5
    phase_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        phase < period);
endmodule

// File: rtl/clksync_gen.sv
// Top: two ratio-programmable clock dividers plus a shared phase counter that
// warns of coincident rising edges. Assumes clk_fast runs at 2*p*q times the
// base rate; the ratio is captured only while rst_n is low.
module clksync_gen
    import clksync_pkg::*;
(
    input  logic             clk_fast,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] ratio_sel,
    output logic             clk_a,
    output logic             clk_c,
    output logic             sync_n
);
    localparam int N_OUT = 2;

    logic [MULT_W-1:0] half_a;
    logic [MULT_W-1:0] half_c;
    logic [PER_W-1:0]  period;
    logic [MULT_W-1:0] halves [N_OUT];
    logic [N_OUT-1:0]  outs;

    clksync_ratio_latch u_latch (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .sel    (ratio_sel),
        .half_a (half_a),
        .half_c (half_c),
        .period (period)
    );

    // Route half-periods to the divider array
    always_comb begin
        halves[0] = half_a;
        halves[1] = half_c;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_div
        clksync_half_div #(.W(MULT_W)) u_div (
            .clk   (clk_fast),
            .rst_n (rst_n),
            .half  (halves[g]),
            .clk_o (outs[g])
        );
    end

    clksync_phase_ctr u_phase (
        .clk    (clk_fast),
        .rst_n  (rst_n),
        .period (period),
        .lead   (half_a),
        .sync_n (sync_n)
    );

    // Drive the output clocks from the divider array
    always_comb begin
        clk_a = outs[0];
        clk_c = outs[1];
    end

    // R2
    reset_state_chk: assert property (@(posedge clk_fast)
        !rst_n |=> (clk_a && clk_c && sync_n));

    // R5
    coincide_warned_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        ($rose(clk_a) && $rose(clk_c)) |-> $past(!sync_n));

    // R6
    sync_release_chk: assert property (@(posedge clk_fast) disable iff (!rst_n)
        $rose(sync_n) |-> ($rose(clk_a) && $rose(clk_c)));
endmodule

// File: tb/clksync_gen_bench.sv
`timescale 1ns/1ps
module clksync_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] sel = 4'd0;
    logic       clk_a, clk_c, sync_n;

    always #2.5 clk = ~clk;

    clksync_gen u_clksync_gen (
        .clk_fast (clk),
        .rst_n    (rst_n),
        .ratio_sel(sel),
        .clk_a    (clk_a),
        .clk_c    (clk_c),
        .sync_n   (sync_n)
    );

    int checks = 0, fails = 0;
    int mp = 1, mq = 1, n = 0;
    int coin = 0, falls = 0;
    bit live = 0, done = 0;
    logic pa = 1, pc = 1, ps = 1;

    // Expected A:C multipliers for each code (R1)
    function automatic void ratio_of(input int code, output int p, output int q);
        case (code)
            1: begin p = 2; q = 1; end   2: begin p = 3; q = 1; end
            3: begin p = 3; q = 2; end   4: begin p = 4; q = 1; end
            5: begin p = 4; q = 3; end   6: begin p = 5; q = 1; end
            7: begin p = 5; q = 2; end   8: begin p = 5; q = 3; end
            9: begin p = 6; q = 1; end  10: begin p = 6; q = 5; end
            default: begin p = 1; q = 1; end
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (code %0d, n=%0d)", tag, act, exp, sel, n);
        end
    endtask

    // Reference model: edges since reset and ratio latched during reset (R8)
    always @(posedge clk) begin
        int tp, tq;
        if (!rst_n) begin
            ratio_of(int'(sel), tp, tq);
            mp <= tp; mq <= tq; n <= 0;
        end else begin
            n <= n + 1;
        end
    end

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (live) begin
            int t;
            t = 2 * mp * mq;
            check(clk_a  == ((n / mq) % 2 == 0), "R1/R3 clk_a", clk_a, (n / mq) % 2 == 0);
            check(clk_c  == ((n / mp) % 2 == 0), "R1/R4 clk_c", clk_c, (n / mp) % 2 == 0);
            check(sync_n == !((n % t) >= t - mq), "R6 sync_n", sync_n, !((n % t) >= t - mq));
            if (!pa && clk_a && !pc && clk_c) coin++;
            if (ps && !sync_n) falls++;
            pa = clk_a; pc = clk_c; ps = sync_n;
        end
    end

    task automatic do_reset(input int code);
        @(negedge clk);
        live = 0; sel = 4'(code); rst_n = 0;
        repeat (2) @(negedge clk);
        #1;
        check(clk_a && clk_c && sync_n, "R2 reset outputs", {clk_a, clk_c, sync_n}, 7);
        pa = 1; pc = 1; ps = 1; coin = 0; falls = 0;
        rst_n = 1;
        @(posedge clk);
        live = 1;
    endtask

    // Run several coincidence periods and count joint rises and sync pulses
    task automatic run_code(input int code, input int periods);
        int p, q, t;
        ratio_of(code, p, q);
        t = 2 * p * q;
        do_reset(code);
        repeat (periods * t - 1) @(posedge clk);
        @(negedge clk); #1;
        check(coin == periods, "R5 coincidences", coin, periods);
        check(falls == periods, "R6 sync pulses", falls, periods);
        if (p == 1 && q == 1)
            check(falls == periods * t / 2, "R7 one sync per period", falls, periods * t / 2);
    endtask

    initial begin
        for (int c = 0; c < 16; c++) run_code(c, 4);
        // R8: change select mid-run; 3:2 waveform must persist
        do_reset(3);
        repeat (5) @(posedge clk);
        @(negedge clk); sel = 4'd10;
        repeat (3 * 12 - 6) @(posedge clk);
        @(negedge clk); #1;
        check(coin == 3, "R8 select ignored, coincidences", coin, 3);
        check(falls == 3, "R8 select ignored, sync pulses", falls, 3);
        live = 0; done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule